// File: doc/BRIEF.md
# Sixty-State BCD Counter Chain

This block counts clock ticks from 00 to 59 in two binary-coded decimal digits, all on one clock. A units digit steps through 0 to 9 on every enabled clock. When it sits at 9 and the enable is high, it passes a step request to the tens digit. The tens digit is cut short at six states, so it returns to 0 when it would otherwise reach 6.

When the combined count reaches 59 and the enable is high, a terminal flag is raised in the same cycle. A registered pulse then follows for one clock. That pulse can enable the next counter in a longer chain. Fed with a 60 Hz tick on the enable, it yields a 1 Hz step.

Every digit changes on the same clock edge, and recycling uses the normal next-state logic. No stage is cleared by a decoded glitch.

Top module: `mod60_bcd_chain`

## Requirements
- R1: While rst_n is low at a rising clock edge, units and tens become 0 and pulse_out becomes 0 after that edge.
- R2: On an enabled edge, units advances by one from 0..8, and goes from 9 back to 0.
- R3: Tens changes only on an enabled edge where units is 9, advancing by one from 0..4.
- R4: On an enabled edge with count 59, tens goes from 5 to 0 on the same edge that units goes from 9 to 0, so the next count is 00.
- R5: When en is low at an edge, neither digit changes.
- R6: tc59 is high in exactly those cycles where en is high and the count is 59 (tens=5, units=9); it is low at 59 when en is low.
- R7: pulse_out is high for the one clock following an edge at which tc59 was high, and low otherwise, so 60 enabled clocks give exactly one pulse.
- R8: Reset takes priority over en: an asserted reset clears both digits even while en is high.
- R9: units never exceeds 9 and tens never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by both digits |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Count tick; one step per clock it is high |
| units | output | 4 | Low BCD digit, 0..9 |
| tens | output | 4 | High BCD digit, 0..5 |
| tc59 | output | 1 | High when en is high and the count is 59 |
| pulse_out | output | 1 | One-clock registered pulse after each wrap from 59 |

## Verification
The bench builds the block with its default moduli, 10 and 6, and a digit width of 4. With these values the full 60-state cycle is short, so the bench runs several complete wraps. It compares every state against a count kept modulo 60 in the bench. With sparse enable patterns it reaches the hold case at every digit value. It also parks the count at 59 with en low and applies reset at a nonzero count while en is high.

// File: rtl/mod60_pkg.sv
// Shared types for the sixty-state counter chain.
// Assumes: each digit stage reports its terminal state and its carry together.
package mod60_pkg;

    // Flags that a digit stage hands to the next stage in the chain
    typedef struct packed {
        logic at_term;   // digit holds its last value
        logic carry;     // digit steps this clock and wraps to zero
    } stage_flags_t;

endpackage

// File: rtl/counter_digit.sv
// One synchronous digit counting 0..MODULUS-1 under a step enable.
// Assumes: MODULUS >= 2 and MODULUS <= 2**W; rst_n is synchronous and active low.
module counter_digit #(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    output logic [W-1:0]            value,
    output mod60_pkg::stage_flags_t flags
);
    localparam logic [W-1:0] LAST = W'(MODULUS - 1);
    localparam logic [W-1:0] ONE  = W'(1);

    logic at_last;

    // Decode the terminal state of this digit
    always_comb begin
        at_last       = (value == LAST);
        flags.at_term = at_last;
        flags.carry   = step_en & at_last;
    end

    // Advance or recycle the digit; reset wins over stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (step_en) begin
            value <= at_last ? '0 : value + ONE;
        end
    end
endmodule

// File: rtl/wrap_pulse.sv
// Registers the chain's terminal carry into a one-clock pulse for the next stage.
// Assumes: carry_in is high for at most one cycle per full count cycle.
module wrap_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic carry_in,
    output logic pulse
);
    // Capture the terminal carry for exactly one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= carry_in;
        end
    end
endmodule

// File: rtl/mod60_bcd_chain.sv
// Two-digit BCD counter 00..59: a decade digit steps a six-state digit.
// Assumes: en is synchronous to clk; the default moduli give a sixty-state count.
module mod60_bcd_chain #(
    parameter int unsigned DIGIT_W   = 4,
    parameter int unsigned UNITS_MOD = 10,
    parameter int unsigned TENS_MOD  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    output logic [DIGIT_W-1:0] units,
    output logic [DIGIT_W-1:0] tens,
    output logic               tc59,
    output logic               pulse_out
);
    localparam int unsigned NUM_STAGES = 2;
    localparam int unsigned MODS [NUM_STAGES] = '{UNITS_MOD, TENS_MOD};

    logic [DIGIT_W-1:0]      digit_val [NUM_STAGES];
    mod60_pkg::stage_flags_t digit_flg [NUM_STAGES];
    logic [NUM_STAGES:0]     step_chain;

    assign step_chain[0] = en;

    // Each stage steps only when every lower stage carries
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        counter_digit #(
            .MODULUS (MODS[s]),
            .W       (DIGIT_W)
        ) u_digit (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (step_chain[s]),
            .value   (digit_val[s]),
            .flags   (digit_flg[s])
        );
        assign step_chain[s+1] = digit_flg[s].carry;
    end

    assign units = digit_val[0];
    assign tens  = digit_val[1];
    assign tc59  = step_chain[NUM_STAGES];

    wrap_pulse u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .carry_in (step_chain[NUM_STAGES]),
        .pulse    (pulse_out)
    );
endmodule

// File: rtl/mod60_bcd_chain_chk.sv
// Property checker for the sixty-state counter chain, bound to the top.
// Assumes: the bench holds rst_n low from time zero.
module mod60_bcd_chain_chk #(
    parameter int unsigned DIGIT_W   = 4,
    parameter int unsigned UNITS_MOD = 10,
    parameter int unsigned TENS_MOD  = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [DIGIT_W-1:0] units,
    input logic [DIGIT_W-1:0] tens,
    input logic               tc59,
    input logic               pulse_out
);
    localparam logic [DIGIT_W-1:0] U_LAST = DIGIT_W'(UNITS_MOD - 1);
    localparam logic [DIGIT_W-1:0] T_LAST = DIGIT_W'(TENS_MOD - 1);
    localparam logic [DIGIT_W-1:0] ONE    = DIGIT_W'(1);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (units == '0 && tens == '0 && !pulse_out)); // R1

    AST_UNITS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && units != U_LAST) |=> units == $past(units) + ONE); // R2

    AST_UNITS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && units == U_LAST) |=> units == '0); // R2

    AST_TENS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (units != U_LAST) |=> $stable(tens)); // R3

    AST_TENS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && units == U_LAST && tens != T_LAST) |=> tens == $past(tens) + ONE); // R3

    AST_TENS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && units == U_LAST && tens == T_LAST) |=> (tens == '0 && units == '0)); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(units) && $stable(tens))); // R5

    AST_TC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tc59 |-> en); // R6

    AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        tc59 |=> pulse_out); // R7

    AST_PULSE_ONLY_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
        !tc59 |=> !pulse_out); // R7

    AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (units <= U_LAST && tens <= T_LAST)); // R9
endmodule

bind mod60_bcd_chain mod60_bcd_chain_chk #(
    .DIGIT_W   (DIGIT_W),
    .UNITS_MOD (UNITS_MOD),
    .TENS_MOD  (TENS_MOD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .units     (units),
    .tens      (tens),
    .tc59      (tc59),
    .pulse_out (pulse_out)
);

// File: tb/sim_mod60_bcd_chain.sv
// Bench: sweeps full count cycles against a modulo-60 model kept in the bench.
module sim_mod60_bcd_chain;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] units;
    logic [3:0] tens;
    logic       tc59;
    logic       pulse_out;

    int checks = 0;
    int failures = 0;
    int model = 0;
    int exp_pulse = 0;
    int pulse_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mod60_bcd_chain u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .units     (units),
        .tens      (tens),
        .tc59      (tc59),
        .pulse_out (pulse_out)
    );

    // Record one check and report a mismatch
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive en at the falling edge, check tc59, then digits after the edge
    task automatic step(input logic e);
        int prev_u;
        int prev_t;
        int exp_tc;
        en = e;
        #1;
        exp_tc = (e && model == 59) ? 1 : 0;
        chk(tc59 == exp_tc, "R6 tc59", tc59, exp_tc);
        prev_u = units;
        prev_t = tens;
        @(posedge clk);
        if (!rst_n) begin
            model = 0;
            exp_pulse = 0;
        end else begin
            exp_pulse = exp_tc;
            if (e) model = (model + 1) % 60;
        end
        @(negedge clk);
        chk(units == model % 10, "R2 units", units, model % 10);
        chk(tens == model / 10, "R3/R4 tens", tens, model / 10);
        chk(pulse_out == exp_pulse, "R7 pulse_out", pulse_out, exp_pulse);
        chk(units <= 9 && tens <= 5, "R9 range", tens * 10 + units, model);
        if (!e && rst_n) begin
            chk(units == prev_u && tens == prev_t, "R5 hold",
                tens * 10 + units, prev_t * 10 + prev_u);
        end
        if (pulse_out) pulse_seen++;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 / R8: reset held with en high
        for (int i = 0; i < 3; i++) step(1'b1);
        chk(units == 0 && tens == 0, "R1 reset digits", tens * 10 + units, 0);
        chk(pulse_out == 0, "R1 reset pulse", pulse_out, 0);
        rst_n = 1'b1;

        // R2 R3 R4 R7: over two full cycles, continuous counting
        pulse_seen = 0;
        for (int i = 0; i < 120; i++) step(1'b1);
        chk(pulse_seen == 2, "R7 pulses per 120 enabled clocks", pulse_seen, 2);

        // R5: sparse enable patterns hold the digits between steps
        for (int i = 0; i < 300; i++) step((i % 3) == 0);
        for (int i = 0; i < 200; i++) step((i % 7) == 2 || (i % 7) == 5);

        // R6: park at 59 with en low, tc59 must stay low and digits hold
        while (model != 59) step(1'b1);
        for (int i = 0; i < 4; i++) step(1'b0);
        chk(tens == 5 && units == 9, "R5 parked at 59", tens * 10 + units, 59);
        // R4: the wrap from 59 goes straight to 00
        step(1'b1);
        chk(tens == 0 && units == 0, "R4 wrap to 00", tens * 10 + units, 0);

        // R7: exactly three pulses in 180 enabled clocks
        pulse_seen = 0;
        for (int i = 0; i < 180; i++) step(1'b1);
        chk(pulse_seen == 3, "R7 pulses per 180 enabled clocks", pulse_seen, 3);

        // R8: reset at a nonzero count while en is high
        while (model != 37) step(1'b1);
        rst_n = 1'b0;
        step(1'b1);
        chk(units == 0 && tens == 0, "R8 reset over en", tens * 10 + units, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 15; i++) step(1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule